// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. Given the table base and the missing virtual address, it fetches a 32-bit first-level descriptor over a simple read handshake. Depending on that descriptor's type field, it either finishes at once with a 1 MB section mapping, fetches a second-level descriptor from a coarse table, or stops with a fault.

A finished walk yields a fill record for the translation buffer. The record holds the mapping kind, the page-aligned physical base, the page-aligned virtual base, the permission bits and the 4-bit domain. A faulting walk reports a fault code and the virtual address that caused it. Fine tables are not walked. A first-level descriptor that points at one gives an "unsupported" fault.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `done_o`, `fault_o`, `mem_req_o` and `busy_o` are low, `fault_code_o` is 0 and `fill_kind_o` is 0 (none).
- R2: One cycle after `start_i` is sampled in idle, `mem_req_o` is high for exactly one cycle. `mem_addr_o` then equals `(ttb | (va >> 18))` with bits [1:0] cleared, and it holds until `mem_ack_i` is sampled.
- R3: A first-level descriptor with bits [1:0] = 2 ends the walk as a section. The outputs are kind 1, pa = desc & 0xFFF00000, va = va & 0xFFF00000, perm = desc[11:0] & 0xC0C and domain = desc[8:5].
- R4: A first-level descriptor with bits [1:0] = 1 starts a second read. `mem_req_o` pulses in the cycle after the first ack. The address is `(desc & 0xFFFFFC00) | ((va & 0x000FF000) >> 10)` with bits [1:0] cleared.
- R5: A second-level descriptor with bits [1:0] = 1 gives kind 2 (large). Both pa and va are masked with 0xFFFF0000.
- R6: A second-level descriptor with bits [1:0] = 2 gives kind 3 (small), and one with 3 gives kind 4 (extended small). Both pa and va are masked with 0xFFFFF000.
- R7: For every page kind, perm = l2[11:0] & 0xFFC and domain = l1[8:5].
- R8: A first-level descriptor with bits [1:0] = 0 raises `fault_o` with code 1. `fault_va_o` then equals the walked virtual address.
- R9: A second-level descriptor with bits [1:0] = 0 raises `fault_o` with code 2 and latches the virtual address.
- R10: A first-level descriptor with bits [1:0] = 3 (fine table) raises `fault_o` with code 3.
- R11: `done_o` and `fault_o` are never high together, and each is high for one cycle only.
- R12: `done_o` or `fault_o` is high in the cycle right after the cycle in which the final `mem_ack_i` is sampled.
- R13: `start_i` is ignored while a walk is in progress, so the virtual address of the running walk is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted in idle only) |
| va_i | input | 32 | Missing virtual address |
| ttb_i | input | 32 | Translation table base |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Fill record valid (one-cycle pulse) |
| fault_o | output | 1 | Walk faulted (one-cycle pulse) |
| fault_code_o | output | 2 | 1 = L1 fault, 2 = L2 fault, 3 = fine table |
| fault_va_o | output | 32 | Virtual address of the faulting walk |
| fill_kind_o | output | 3 | 0 none, 1 section, 2 large, 3 small, 4 extended small |
| fill_va_o | output | 32 | Aligned virtual base |
| fill_pa_o | output | 32 | Aligned physical base |
| fill_perm_o | output | 12 | Permission bits |
| fill_domain_o | output | 4 | Domain number |

## Verification
The first request is due one cycle after start is sampled. Each result (done or fault) is due one cycle after the final ack is sampled, and a second-level request is due in that same following cycle. The bench drives every input on the falling edge and samples outputs on the falling edge in exactly those cycles. One further falling edge later, it confirms that the pulse has dropped. Memory latency varies from zero to three wait cycles, so the holding of the address and the ack-relative timing of the result are exercised beyond the back-to-back case.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned PERM_W = 12;
  parameter int unsigned DOM_W  = 4;
  parameter int unsigned DOM_LSB = 5;
  parameter int unsigned L1_SHIFT = 18;
  parameter int unsigned L2_IDX_SHIFT = 10;

  localparam logic [WORD_W-1:0] ALIGN_MASK    = {{(WORD_W-2){1'b1}}, 2'b00};
  localparam logic [WORD_W-1:0] L2_BASE_MASK  = 32'hFFFF_FC00;
  localparam logic [WORD_W-1:0] L2_IDX_MASK   = 32'h000F_F000;
  localparam logic [PERM_W-1:0] SEC_PERM_MASK = 12'hC0C;
  localparam logic [PERM_W-1:0] PG_PERM_MASK  = 12'hFFC;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_SECTION = 3'd1,
    KIND_LARGE   = 3'd2,
    KIND_SMALL   = 3'd3,
    KIND_XSMALL  = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_L1   = 2'd1,
    FLT_L2   = 2'd2,
    FLT_FINE = 2'd3
  } fcode_e;

  typedef struct packed {
    kind_e              kind;
    logic [WORD_W-1:0]  va;
    logic [WORD_W-1:0]  pa;
    logic [PERM_W-1:0]  perm;
    logic [DOM_W-1:0]   dom;
  } fill_t;

  function automatic logic [WORD_W-1:0] kind_mask(kind_e k);
    case (k)
      KIND_SECTION: return 32'hFFF0_0000;
      KIND_LARGE:   return 32'hFFFF_0000;
      KIND_SMALL,
      KIND_XSMALL:  return 32'hFFFF_F000;
      default:      return '0;
    endcase
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] ttb_i,
  input  logic [WORD_W-1:0] va_i,
  input  logic [WORD_W-1:0] l1_desc_i,
  output logic [WORD_W-1:0] l1_addr_o,
  output logic [WORD_W-1:0] l2_addr_o
);
  assign l1_addr_o = (ttb_i | (va_i >> L1_SHIFT)) & ALIGN_MASK;
  assign l2_addr_o = ((l1_desc_i & L2_BASE_MASK) |
                      ((va_i & L2_IDX_MASK) >> L2_IDX_SHIFT)) & ALIGN_MASK;
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
  import ptw_pkg::*;
(
  input  logic              lvl2_i,
  input  logic [WORD_W-1:0] va_i,
  input  logic [WORD_W-1:0] l1_i,
  input  logic [WORD_W-1:0] l2_i,
  output fill_t             fill_o,
  output fcode_e            fcode_o,
  output logic              next_lvl_o
);
  kind_e             kind;
  logic [WORD_W-1:0] src;
  logic [WORD_W-1:0] mask;

  always_comb begin
    kind       = KIND_NONE;
    fcode_o    = FLT_NONE;
    next_lvl_o = 1'b0;
    if (!lvl2_i) begin
      case (l1_i[1:0])
        2'd0: fcode_o = FLT_L1;
        2'd1: next_lvl_o = 1'b1;
        2'd2: kind = KIND_SECTION;
        default: fcode_o = FLT_FINE;
      endcase
    end else begin
      case (l2_i[1:0])
        2'd0: fcode_o = FLT_L2;
        2'd1: kind = KIND_LARGE;
        2'd2: kind = KIND_SMALL;
        default: kind = KIND_XSMALL;
      endcase
    end
  end

  assign src  = lvl2_i ? l2_i : l1_i;
  assign mask = kind_mask(kind);

  always_comb begin
    fill_o.kind = kind;
    fill_o.va   = va_i & mask;
    fill_o.pa   = src & mask;
    fill_o.perm = lvl2_i ? (l2_i[PERM_W-1:0] & PG_PERM_MASK)
                         : (l1_i[PERM_W-1:0] & SEC_PERM_MASK);
    fill_o.dom  = l1_i[DOM_LSB +: DOM_W];
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] va_i,
  input  logic [WORD_W-1:0] ttb_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [WORD_W-1:0] fault_va_o,
  output logic [2:0]        fill_kind_o,
  output logic [WORD_W-1:0] fill_va_o,
  output logic [WORD_W-1:0] fill_pa_o,
  output logic [PERM_W-1:0] fill_perm_o,
  output logic [DOM_W-1:0]  fill_domain_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
  } state_e;

  state_e            state_q;
  logic [WORD_W-1:0] va_q, ttb_q, l1_q, fault_va_q;
  fill_t             fill_q;
  fcode_e            fcode_q;

  logic [WORD_W-1:0] l1_addr, l2_addr, dec_l1;
  fill_t             dec_fill;
  fcode_e            dec_fcode;
  logic              dec_next, lvl2;

  assign lvl2   = (state_q == ST_L2_WAIT);
  assign dec_l1 = lvl2 ? l1_q : mem_rdata_i;

  ptw_addr_gen u_addr (
    .ttb_i     (ttb_q),
    .va_i      (va_q),
    .l1_desc_i (l1_q),
    .l1_addr_o (l1_addr),
    .l2_addr_o (l2_addr)
  );

  ptw_decode u_dec (
    .lvl2_i     (lvl2),
    .va_i       (va_q),
    .l1_i       (dec_l1),
    .l2_i       (mem_rdata_i),
    .fill_o     (dec_fill),
    .fcode_o    (dec_fcode),
    .next_lvl_o (dec_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      ttb_q      <= '0;
      l1_q       <= '0;
      fault_va_q <= '0;
      fill_q     <= '0;
      fcode_q    <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= va_i;
          ttb_q   <= ttb_i;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_ack_i) begin
          l1_q <= mem_rdata_i;
          if (dec_fcode != FLT_NONE) begin
            fcode_q    <= dec_fcode;
            fault_va_q <= va_q;
            state_q    <= ST_FAULT;
          end else if (dec_next) begin
            state_q <= ST_L2_REQ;
          end else begin
            fill_q  <= dec_fill;
            state_q <= ST_DONE;
          end
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_ack_i) begin
          if (dec_fcode != FLT_NONE) begin
            fcode_q    <= dec_fcode;
            fault_va_q <= va_q;
            state_q    <= ST_FAULT;
          end else begin
            fill_q  <= dec_fill;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o     = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o    = (state_q == ST_L2_REQ || state_q == ST_L2_WAIT) ? l2_addr : l1_addr;
  assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_DONE) && (state_q != ST_FAULT);
  assign done_o        = (state_q == ST_DONE);
  assign fault_o       = (state_q == ST_FAULT);
  assign fault_code_o  = fcode_q;
  assign fault_va_o    = fault_va_q;
  assign fill_kind_o   = fill_q.kind;
  assign fill_va_o     = fill_q.va;
  assign fill_pa_o     = fill_q.pa;
  assign fill_perm_o   = fill_q.perm;
  assign fill_domain_o = fill_q.dom;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_L1_WAIT || state_q == ST_L2_WAIT) && !mem_ack_i) |=> $stable(mem_addr_o)); // R2
  AST_SECTION_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fill_kind_o == KIND_SECTION) |-> (fill_pa_o[19:0] == '0)); // R3
  AST_FAULT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (fault_code_o != FLT_NONE)); // R8
  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R11
  AST_RESULT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !(done_o || fault_o)); // R11
  AST_RESULT_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> $past(mem_ack_i)); // R12
  AST_VA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$rose(busy_o)) |-> $stable(va_q)); // R13
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va_in = '0, ttb_in = '0, rdata = '0;
  logic        ack = 1'b0;
  logic        req, busy, done, fault;
  logic [31:0] addr, fva, f_va, f_pa;
  logic [1:0]  fcode;
  logic [2:0]  fkind;
  logic [11:0] fperm;
  logic [3:0]  fdom;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic        g_done, g_fault;
  logic [1:0]  g_code;
  logic [31:0] g_fva, g_va, g_pa;
  logic [2:0]  g_kind;
  logic [11:0] g_perm;
  logic [3:0]  g_dom;

  always #4 clk = ~clk;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .va_i(va_in), .ttb_i(ttb_in),
    .mem_req_o(req), .mem_addr_o(addr), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_code_o(fcode),
    .fault_va_o(fva), .fill_kind_o(fkind), .fill_va_o(f_va), .fill_pa_o(f_pa),
    .fill_perm_o(fperm), .fill_domain_o(fdom)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int k);
    case (k)
      1: return 32'hFFF0_0000;
      2: return 32'hFFFF_0000;
      3, 4: return 32'hFFFF_F000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic run_walk(input logic [31:0] va, ttb, l1, l2, input int lat, input bit poke);
    logic [31:0] e_l1, e_l2;
    e_l1 = (ttb | (va >> 18)) & ~32'h3;
    e_l2 = ((l1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10)) & ~32'h3;
    @(negedge clk); start = 1'b1; va_in = va; ttb_in = ttb;
    @(negedge clk); start = 1'b0;
    chk("R2 req pulse", {31'b0, req}, 32'd1);
    chk("R2 l1 addr", addr, e_l1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin start = 1'b1; va_in = 32'hFFFF_FFFF; end
      else begin start = 1'b0; va_in = va; end
      chk("R2 req low in wait", {31'b0, req}, 32'd0);
      chk("R2 addr held", addr, e_l1);
    end
    @(negedge clk); start = 1'b0; va_in = va; ack = 1'b1; rdata = l1;
    @(negedge clk); ack = 1'b0; rdata = '0;
    if (l1[1:0] == 2'd1) begin
      chk("R4 l2 req", {31'b0, req}, 32'd1);
      chk("R4 l2 addr", addr, e_l2);
      repeat (lat) @(negedge clk);
      @(negedge clk); ack = 1'b1; rdata = l2;
      @(negedge clk); ack = 1'b0; rdata = '0;
    end
    g_done = done; g_fault = fault; g_code = fcode; g_fva = fva;
    g_kind = fkind; g_va = f_va; g_pa = f_pa; g_perm = fperm; g_dom = fdom;
    chk("R12 result after ack", {31'b0, done | fault}, 32'd1);
    chk("R11 exclusive", {31'b0, done & fault}, 32'd0);
    @(negedge clk);
    chk("R11 one cycle", {30'b0, done, fault}, 32'd0);
  endtask

  task automatic expect_fill(input string tag, input int kind, input logic [31:0] src, va,
                             input logic [11:0] perm, input logic [3:0] dom);
    chk({tag, " done"}, {31'b0, g_done}, 32'd1);
    chk({tag, " kind"}, {29'b0, g_kind}, kind);
    chk({tag, " pa"}, g_pa, src & mask_of(kind));
    chk({tag, " va"}, g_va, va & mask_of(kind));
    chk({tag, " perm"}, {20'b0, g_perm}, {20'b0, perm});
    chk({tag, " dom"}, {28'b0, g_dom}, {28'b0, dom});
  endtask

  task automatic expect_fault(input string tag, input int code, input logic [31:0] va);
    chk({tag, " fault"}, {31'b0, g_fault}, 32'd1);
    chk({tag, " code"}, {30'b0, g_code}, code);
    chk({tag, " fva"}, g_fva, va);
  endtask

  task automatic t_reset();
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 fault", {31'b0, fault}, 0);
    chk("R1 req", {31'b0, req}, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 code", {30'b0, fcode}, 0);
    chk("R1 kind", {29'b0, fkind}, 0);
  endtask

  task automatic t_section();
    run_walk(32'h1234_5678, 32'h0000_4000, 32'hABC0_0D2E, 32'h0, 2, 0);
    expect_fill("R3 section", 1, 32'hABC0_0D2E, 32'h1234_5678, 12'hC0C, 4'h9);
  endtask

  task automatic t_large();
    run_walk(32'h0ABC_D123, 32'h0000_8000, 32'h0020_8061, 32'h7777_5AB5, 1, 0);
    expect_fill("R5 R7 large", 2, 32'h7777_5AB5, 32'h0ABC_D123, 12'hAB4, 4'h3);
  endtask

  task automatic t_small();
    run_walk(32'hFEDC_B9A8, 32'h0000_C000, 32'h0031_01E1, 32'h4321_6FFE, 0, 0);
    expect_fill("R6 R7 small", 3, 32'h4321_6FFE, 32'hFEDC_B9A8, 12'hFFC, 4'hF);
  endtask

  task automatic t_xsmall();
    run_walk(32'h0000_1234, 32'h0001_0000, 32'h0040_0041, 32'h8765_4553, 3, 0);
    expect_fill("R6 R7 xsmall", 4, 32'h8765_4553, 32'h0000_1234, 12'h550, 4'h2);
  endtask

  task automatic t_l1_fault();
    run_walk(32'h8765_4321, 32'h0002_0000, 32'h1234_5670, 32'h0, 1, 0);
    expect_fault("R8 l1 fault", 1, 32'h8765_4321);
  endtask

  task automatic t_l2_fault();
    run_walk(32'h3000_5000, 32'h0003_0000, 32'h0050_0021, 32'hFFFF_F000, 2, 0);
    expect_fault("R9 l2 fault", 2, 32'h3000_5000);
  endtask

  task automatic t_fine();
    run_walk(32'h4400_0000, 32'h0004_0000, 32'h0000_1233, 32'h0, 0, 0);
    expect_fault("R10 fine", 3, 32'h4400_0000);
  endtask

  task automatic t_busy_ignore();
    run_walk(32'h5670_0ABC, 32'h0005_0000, 32'h9990_0002, 32'h0, 3, 1);
    expect_fill("R13 busy ignore", 1, 32'h9990_0002, 32'h5670_0ABC, 12'h000, 4'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section();
    t_large();
    t_small();
    t_xsmall();
    t_l1_fault();
    t_l2_fault();
    t_fine();
    t_busy_ignore();
    t_section();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule